// File: doc/BRIEF.md
# Relative-Addressed Register Stack

This block holds eight data registers arranged as a circular stack. A three-bit top pointer moves on every push and pop. Operands are named ST(0) to ST(7) by their distance from the current top, so the physical slot of ST(i) is (top + i) mod 8. Any slot can be read, written, exchanged with ST(0), or used as the destination of an arithmetic result. The stack can therefore serve as a single accumulator with seven free registers, or as several independent accumulators.

An integer adder/subtractor stands in for a real arithmetic unit. It combines ST(0) with either ST(i) or an operand supplied from outside the block. The result goes to ST(0) by default. A per-operation reverse option sends it to ST(i) instead, and a pop-after option then frees ST(0).

Each physical slot carries a valid tag. An operation that would push onto an occupied slot, or that would read an empty one, is refused: the block raises a flag and changes no state. One operation is accepted per clock. Its results appear on registered outputs in the next cycle.

Top module: `regstack_top`

## Requirements
- R1: After reset, top_ptr is 0, every slot is empty, and done, overflow, underflow and data_out are all 0.
- R2: ST(i) is the physical slot (top + i) mod 8. The read operation (op code 3) returns ST(idx) on data_out.
- R3: Push (op code 1) decrements top modulo 8 and stores data_in as the new ST(0), marking it valid. Pop (op code 2) returns ST(0) on data_out, marks that slot empty and increments top modulo 8.
- R4: Write (op code 4) stores data_in into ST(idx) and marks it valid, whatever its previous tag. data_out is 0 for this operation.
- R5: Exchange (op code 5) swaps the contents of ST(0) and ST(idx) in one operation, and data_out shows the new ST(0). An exchange with idx 0 leaves the stack as it was.
- R6: The arithmetic operation (op code 6) takes A = ST(0) and B = mem_operand when use_mem is 1, otherwise B = ST(idx). It computes A+B for fn 00 or 11, A−B for fn 01, and B−A for fn 10, all modulo 2^DATA_W. The result appears on data_out and, by default, is written to ST(0).
- R7: With reverse set and use_mem at 0, the result is written to ST(idx) and ST(0) is unchanged. With use_mem at 1, reverse has no effect.
- R8: With pop_after set, a successful arithmetic operation writes its result, then marks the slot that was ST(0) empty and increments top.
- R9: A push whose target slot is already valid sets overflow for one cycle, leaves top and every slot unchanged, and returns 0 on data_out.
- R10: An operation that must read an empty slot sets underflow for one cycle, leaves top and every slot unchanged, and returns 0 on data_out. These cases are a pop or read of an empty slot, an exchange where either slot is empty, and an arithmetic operation whose ST(0) or (with use_mem at 0) ST(idx) is empty.
- R11: When start is high at a clock edge, done is high for exactly the next cycle, with data_out and the flags valid. When start is low, done stays low. Op codes 0 and 7 do nothing but produce done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code |
| idx | input | PTR_W | Offset i of the ST(i) operand |
| fn | input | 2 | Arithmetic function select |
| use_mem | input | 1 | Take B from mem_operand instead of ST(idx) |
| reverse | input | 1 | Write the arithmetic result to ST(idx) |
| pop_after | input | 1 | Pop after the arithmetic result is written |
| data_in | input | DATA_W | Value for push and write |
| mem_operand | input | DATA_W | External arithmetic operand |
| done | output | 1 | Operation completed last cycle |
| data_out | output | DATA_W | Result or read value |
| top_ptr | output | PTR_W | Current top pointer |
| overflow | output | 1 | Last push was refused |
| underflow | output | 1 | Last operation read an empty slot |

## Verification
A wrong top pointer or a wrong offset sum shows at once on top_ptr. It also shows on the very next read or pop, because the wrong slot is returned or a spurious underflow appears. A corrupted valid tag is only exposed when that slot is next touched: an occupied slot turns up as overflow on a push, and a freed one turns up as underflow on a read. The bench keeps a full model of contents, tags and pointer, and compares every returned value and flag one cycle after each operation. This catches such faults within the few operations that reach the affected slot.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_XCHG  = 3'd5,
    OP_ARITH = 3'd6,
    OP_IDLE  = 3'd7
  } op_t;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_SUB  = 2'd1,
    FN_RSUB = 2'd2,
    FN_ADDB = 2'd3
  } fn_t;
endpackage

// File: rtl/regstack_ptr.sv
module regstack_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [PTR_W-1:0] idx,
  output logic [PTR_W-1:0] top_o,
  output logic [PTR_W-1:0] p0_o,
  output logic [PTR_W-1:0] pi_o,
  output logic [PTR_W-1:0] pm1_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
    end else if (inc && !dec) begin
      top_q <= top_q + ONE;
    end else if (dec && !inc) begin
      top_q <= top_q - ONE;
    end
  end

  always_comb begin
    top_o = top_q;
    p0_o  = top_q;
    pi_o  = top_q + idx;   // offset addressing wraps by width
    pm1_o = top_q - ONE;
  end

  // R3: the pointer moves by at most one slot per operation
  p_top_step_r3: assert property (@(posedge clk) disable iff (rst)
    (top_q != $past(top_q)) |->
      ((top_q == $past(top_q) + ONE) || (top_q == $past(top_q) - ONE)));
endmodule

// File: rtl/regstack_alu.sv
module regstack_alu
  import regstack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        fn,
  output logic [DATA_W-1:0] y
);
  fn_t fn_e;

  always_comb begin
    fn_e = fn_t'(fn);
    case (fn_e)
      FN_SUB:  y = a - b;
      FN_RSUB: y = b - a;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/regstack_file.sv
module regstack_file #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  ra,
  input  logic [PTR_W-1:0]  rb,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we_a,
  input  logic [PTR_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [PTR_W-1:0]  wb,
  input  logic [DATA_W-1:0] wd_b,
  input  logic              clr,
  input  logic [PTR_W-1:0]  ca,
  output logic [(1<<PTR_W)-1:0] tags_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  tag_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    localparam logic [PTR_W-1:0] ME = PTR_W'(e);

    always_ff @(posedge clk) begin
      if (we_a && wa == ME) begin
        slot_q[e] <= wd_a;
      end else if (we_b && wb == ME) begin
        slot_q[e] <= wd_b;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[e] <= 1'b0;
      end else if (clr && ca == ME) begin
        tag_q[e] <= 1'b0;
      end else if ((we_a && wa == ME) || (we_b && wb == ME)) begin
        tag_q[e] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_a   = slot_q[ra];
    rd_b   = slot_q[rb];
    tags_o = tag_q;
  end

  // R5: the two write ports never target the same slot
  p_port_clash_r5: assert property (@(posedge clk) disable iff (rst)
    (we_a && we_b) |-> (wa != wb));

  // R3: only an occupied slot is ever freed
  p_clr_valid_r3: assert property (@(posedge clk) disable iff (rst)
    clr |-> tag_q[ca]);
endmodule

// File: rtl/regstack_top.sv
module regstack_top
  import regstack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [PTR_W-1:0]  idx,
  input  logic [1:0]        fn,
  input  logic              use_mem,
  input  logic              reverse,
  input  logic              pop_after,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] mem_operand,
  output logic              done,
  output logic [DATA_W-1:0] data_out,
  output logic [PTR_W-1:0]  top_ptr,
  output logic              overflow,
  output logic              underflow
);
  localparam int DEPTH = 1 << PTR_W;

  op_t               op_e;
  logic [PTR_W-1:0]  top_w, p0, pi, pm1;
  logic              inc, dec;
  logic [DATA_W-1:0] rd_a, rd_b, b_opnd, alu_y, res;
  logic [DEPTH-1:0]  tags;
  logic              wa_en, wb_en, clr_en;
  logic [PTR_W-1:0]  wa_addr, wb_addr;
  logic [DATA_W-1:0] wa_data, wb_data;
  logic              ovf_n, unf_n;
  logic              done_q, ovf_q, unf_q;
  logic [DATA_W-1:0] dout_q;

  regstack_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .inc(inc), .dec(dec), .idx(idx),
    .top_o(top_w), .p0_o(p0), .pi_o(pi), .pm1_o(pm1)
  );

  regstack_file #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_file (
    .clk(clk), .rst(rst),
    .ra(p0), .rb(pi), .rd_a(rd_a), .rd_b(rd_b),
    .we_a(wa_en), .wa(wa_addr), .wd_a(wa_data),
    .we_b(wb_en), .wb(wb_addr), .wd_b(wb_data),
    .clr(clr_en), .ca(p0), .tags_o(tags)
  );

  assign b_opnd = use_mem ? mem_operand : rd_b;

  regstack_alu #(.DATA_W(DATA_W)) u_alu (
    .a(rd_a), .b(b_opnd), .fn(fn), .y(alu_y)
  );

  always_comb begin
    op_e    = op_t'(op);
    wa_en   = 1'b0;
    wa_addr = p0;
    wa_data = data_in;
    wb_en   = 1'b0;
    wb_addr = pi;
    wb_data = rd_a;
    clr_en  = 1'b0;
    inc     = 1'b0;
    dec     = 1'b0;
    res     = '0;
    ovf_n   = 1'b0;
    unf_n   = 1'b0;
    if (start) begin
      case (op_e)
        OP_PUSH: begin
          if (tags[pm1]) begin
            ovf_n = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = pm1;
            dec     = 1'b1;
          end
        end
        OP_POP: begin
          if (!tags[p0]) begin
            unf_n = 1'b1;
          end else begin
            res    = rd_a;
            clr_en = 1'b1;
            inc    = 1'b1;
          end
        end
        OP_READ: begin
          if (!tags[pi]) unf_n = 1'b1;
          else           res   = rd_b;
        end
        OP_WRITE: begin
          wa_en   = 1'b1;
          wa_addr = pi;
        end
        OP_XCHG: begin
          if (!tags[p0] || !tags[pi]) begin
            unf_n = 1'b1;
          end else begin
            res = rd_b;
            if (idx != '0) begin
              wa_en   = 1'b1;
              wa_addr = p0;
              wa_data = rd_b;
              wb_en   = 1'b1;
            end
          end
        end
        OP_ARITH: begin
          if (!tags[p0] || (!use_mem && !tags[pi])) begin
            unf_n = 1'b1;
          end else begin
            res     = alu_y;
            wa_en   = 1'b1;
            wa_addr = (reverse && !use_mem) ? pi : p0;
            wa_data = alu_y;
            if (pop_after) begin
              clr_en = 1'b1;
              inc    = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      done_q <= start;
      ovf_q  <= ovf_n;
      unf_q  <= unf_n;
      if (start) dout_q <= res;
    end
  end

  assign done      = done_q;
  assign data_out  = dout_q;
  assign top_ptr   = top_w;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

  // R11: one done per accepted operation, in the next cycle
  p_done_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  // R9: a refused push leaves the pointer where it was
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (top_ptr == $past(top_ptr)));
  // R10: an underflow leaves the pointer where it was
  p_unf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (top_ptr == $past(top_ptr)));
  // R10: flags only accompany a completed operation, never together
  p_flag_done_r10: assert property (@(posedge clk) disable iff (rst)
    (overflow || underflow) |-> (done && !(overflow && underflow)));
endmodule

// File: tb/tb_regstack_top.sv
`timescale 1ns/1ps
module tb_regstack_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [2:0] idx = '0;
  logic [1:0] fn = '0;
  logic use_mem = 1'b0, reverse = 1'b0, pop_after = 1'b0;
  logic [W-1:0] data_in = '0, mem_operand = '0;
  logic done, overflow, underflow;
  logic [W-1:0] data_out;
  logic [2:0] top_ptr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [W-1:0] mval [8];
  bit           mtag [8];
  int           mtop;

  always #2.5 clk = ~clk;

  regstack_top #(.DATA_W(W), .PTR_W(3)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .idx(idx), .fn(fn),
    .use_mem(use_mem), .reverse(reverse), .pop_after(pop_after),
    .data_in(data_in), .mem_operand(mem_operand), .done(done),
    .data_out(data_out), .top_ptr(top_ptr), .overflow(overflow),
    .underflow(underflow)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int o, bit um, bit rv, bit pa);
    case (o)
      1: return "R3";
      2: return "R3";
      3: return "R2";
      4: return "R4";
      5: return "R5";
      6: return pa ? "R8" : ((rv || um) ? "R7" : "R6");
      default: return "R11";
    endcase
  endfunction

  task automatic do_op(int o, int i, int f, bit um, bit rv, bit pa,
                       logic [W-1:0] din, logic [W-1:0] mop);
    int p0, pi, pm1, dst;
    logic [W-1:0] ed, a, b, r, t;
    bit eovf, eunf;
    string rq;
    p0 = mtop; pi = (mtop + i) % 8; pm1 = (mtop + 7) % 8;
    ed = '0; eovf = 0; eunf = 0;
    case (o)
      1: if (mtag[pm1]) eovf = 1;
         else begin mval[pm1] = din; mtag[pm1] = 1; mtop = pm1; end
      2: if (!mtag[p0]) eunf = 1;
         else begin ed = mval[p0]; mtag[p0] = 0; mtop = (mtop + 1) % 8; end
      3: if (!mtag[pi]) eunf = 1; else ed = mval[pi];
      4: begin mval[pi] = din; mtag[pi] = 1; end
      5: if (!mtag[p0] || !mtag[pi]) eunf = 1;
         else begin ed = mval[pi]; t = mval[p0]; mval[p0] = mval[pi]; mval[pi] = t; end
      6: begin
        a = mval[p0];
        b = um ? mop : mval[pi];
        if (!mtag[p0] || (!um && !mtag[pi])) eunf = 1;
        else begin
          r = (f == 1) ? a - b : (f == 2) ? b - a : a + b;
          ed = r;
          dst = (rv && !um) ? pi : p0;
          mval[dst] = r; mtag[dst] = 1;
          if (pa) begin mtag[p0] = 0; mtop = (mtop + 1) % 8; end
        end
      end
      default: ;
    endcase
    @(negedge clk);
    start = 1'b1; op = o[2:0]; idx = i[2:0]; fn = f[1:0];
    use_mem = um; reverse = rv; pop_after = pa; data_in = din; mem_operand = mop;
    @(posedge clk);
    #1;
    rq = req_of(o, um, rv, pa);
    check("R11", "done", int'(done), 1);
    check(rq, "data_out", int'(data_out), int'(ed));
    check(eovf ? "R9" : rq, "overflow", int'(overflow), int'(eovf));
    check(eunf ? "R10" : rq, "underflow", int'(underflow), int'(eunf));
    check(rq, "top_ptr", int'(top_ptr), mtop);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    #1;
    check("R11", "done idle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int k = 0; k < 8; k++) begin mval[k] = '0; mtag[k] = 0; end
    mtop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", "top_ptr", int'(top_ptr), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "overflow", int'(overflow), 0);
    check("R1", "underflow", int'(underflow), 0);
    check("R1", "data_out", int'(data_out), 0);
    for (int k = 0; k < 8; k++) do_op(3, k, 0, 0, 0, 0, 0, 0); // R1 all empty
    // R3 fill, R9 overflow
    for (int k = 0; k < 8; k++) do_op(1, 0, 0, 0, 0, 0, 16'(10 * (k + 1)), 0);
    do_op(1, 0, 0, 0, 0, 0, 16'd999, 0);
    for (int k = 0; k < 8; k++) do_op(3, k, 0, 0, 0, 0, 0, 0); // R2, R9 unchanged
    // R5 exchange
    do_op(5, 3, 0, 0, 0, 0, 0, 0);
    do_op(5, 0, 0, 0, 0, 0, 0, 0);
    do_op(3, 3, 0, 0, 0, 0, 0, 0);
    // R6 arithmetic variants
    do_op(6, 0, 0, 1, 0, 0, 0, 16'd5);
    do_op(6, 2, 1, 0, 0, 0, 0, 0);
    do_op(6, 2, 2, 0, 0, 0, 0, 0);
    do_op(6, 1, 3, 0, 0, 0, 0, 0);
    do_op(6, 0, 1, 1, 0, 0, 0, 16'hFFFF);
    // R7 reverse
    do_op(6, 4, 0, 0, 1, 0, 0, 0);
    do_op(3, 0, 0, 0, 0, 0, 0, 0);
    do_op(3, 4, 0, 0, 0, 0, 0, 0);
    do_op(6, 4, 0, 1, 1, 0, 0, 16'd7);
    do_op(3, 4, 0, 0, 0, 0, 0, 0);
    // R8 pop after
    do_op(6, 5, 1, 0, 1, 1, 0, 0);
    do_op(3, 4, 0, 0, 0, 0, 0, 0);
    do_op(3, 7, 0, 0, 0, 0, 0, 0);
    // R3 / R10 drain and underflow
    for (int k = 0; k < 8; k++) do_op(2, 0, 0, 0, 0, 0, 0, 0);
    do_op(5, 2, 0, 0, 0, 0, 0, 0);
    do_op(6, 0, 0, 1, 0, 0, 0, 16'd1);
    // R4 write then read back
    do_op(4, 5, 0, 0, 0, 0, 16'd1234, 0);
    do_op(3, 5, 0, 0, 0, 0, 0, 0);
    do_op(6, 5, 0, 0, 0, 0, 0, 0);
    // R11 idle and no-op codes
    idle_cycle();
    do_op(0, 0, 0, 0, 0, 0, 16'd77, 0);
    do_op(7, 1, 0, 0, 0, 0, 16'd77, 0);
    idle_cycle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int o;
      o = int'($urandom % 8);
      if (($urandom % 4) == 0) o = 1;
      do_op(o, int'($urandom % 8), int'($urandom % 4), bit'($urandom % 2),
            bit'($urandom % 2), bit'($urandom % 2), 16'($urandom), 16'($urandom));
      if (($urandom % 16) == 0) idle_cycle();
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule